// File: doc/BRIEF.md
# Jump-and-Link Next-PC and Writeback Unit

This block is the program-counter and destination-register slice of a single-cycle RV32I core. It covers load-upper-immediate, jump-and-link and register-indirect jump-and-link, and it passes R-type ALU results through. Each cycle it decodes the fetched word and chooses the next PC from three candidates: the sequential address, a PC-relative target or an rs1-relative target. It also picks the value bound for the destination register from the ALU result, the upper immediate or the link address.

The write port to the register file is registered. It is loaded on the same edge that loads the PC. After a jump, the PC therefore already holds the target while the write port still presents the address that followed the jump instruction. The link can never pick up the PC+4 of the new PC. The writeback selection uses two one-bit selects with fixed priority. The upper-immediate select wins over the link select, and the ALU result is the default.

Top module: `jl_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `pc` becomes RESET_PC (default 0), `regWe` becomes 0, and `rdIdx` and `rdData` become 0.
- R2: For an instruction that does not jump, `pc` advances by 4 at the next edge.
- R3: Opcode 0110011 (R-type) writes `aluResult` to rd, which is bits 11:7.
- R4: Opcode 0110111 writes bits 31:12 of the word into bits 31:12 of rd and zeros into bits 11:0.
- R5: Opcode 1101111 loads `pc` with the old PC plus the sign-extended J-type offset. The offset bits are {w[31], w[19:12], w[20], w[30:21], 0}.
- R6: Opcode 1100111 with funct3 (bits 14:12) equal to 000 loads `pc` with `rs1Val` plus the sign-extended bits 31:20, with bit 0 cleared. The target does not depend on the PC.
- R7: Both jump forms write the old PC+4 to rd. This value is present on `rdData` in the cycle after the edge, while `pc` already holds the target. It holds even when rd equals rs1.
- R8: When rd is x0, `regWe` stays 0.
- R9: Any other opcode, and the register-indirect jump opcode with a nonzero funct3, writes nothing and advances `pc` by 4.
- R10: `regWe`, `rdIdx` and `rdData` are registered. They describe the instruction presented before the most recent edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Instruction word fetched at `pc` |
| rs1Val | input | XLEN | Value read from rs1 |
| aluResult | input | XLEN | ALU result for the current instruction |
| pc | output | XLEN | Program counter register |
| regWe | output | 1 | Register-file write enable (registered) |
| rdIdx | output | 5 | Destination register index (registered) |
| rdData | output | XLEN | Destination write data (registered) |

## Verification
The bench builds the block with its defaults: XLEN of 32 and RESET_PC of 0. With these values the PC wraps at 32 bits, so random jump offsets over the whole 21-bit range can cross address zero, and the bench checks the wrap arithmetic. Starting from address 0 makes the first sequential and link values easy to predict. The directed cases reach a register-indirect jump whose rd equals rs1, an odd register-indirect target, a write to x0 and a bad funct3.

// File: rtl/jl_pkg.sv
package jl_pkg;
  localparam logic [6:0] OP_RTYPE = 7'b0110011;
  localparam logic [6:0] OP_UPPER = 7'b0110111;
  localparam logic [6:0] OP_JUMP  = 7'b1101111;
  localparam logic [6:0] OP_JREG  = 7'b1100111;

  typedef struct packed {
    logic regWrite;  // instruction writes rd
    logic selUpper;  // original writeback select: upper immediate
    logic selLink;   // added writeback select: link address
    logic jumpPc;    // PC-relative target
    logic jumpReg;   // rs1-relative target
  } jlCtrl_t;
endpackage

// File: rtl/jl_control.sv
module jl_control
  import jl_pkg::*;
(
  input  logic [6:0] opcode,
  input  logic [2:0] funct3,
  output jlCtrl_t    ctrl
);
  always_comb begin
    ctrl = '0;
    unique case (opcode)
      OP_RTYPE: ctrl.regWrite = 1'b1;
      OP_UPPER: begin
        ctrl.regWrite = 1'b1;
        ctrl.selUpper = 1'b1;
      end
      OP_JUMP: begin
        ctrl.regWrite = 1'b1;
        ctrl.selLink  = 1'b1;
        ctrl.jumpPc   = 1'b1;
      end
      OP_JREG: begin
        if (funct3 == 3'b000) begin
          ctrl.regWrite = 1'b1;
          ctrl.selLink  = 1'b1;
          ctrl.jumpReg  = 1'b1;
        end
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/jl_datapath.sv
module jl_datapath
  import jl_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] rs1Val,
  input  logic [XLEN-1:0] aluResult,
  input  jlCtrl_t         ctrl,
  output logic [XLEN-1:0] pc,
  output logic            regWe,
  output logic [4:0]      rdIdx,
  output logic [XLEN-1:0] rdData
);
  localparam logic [XLEN-1:0] INSTR_STEP = XLEN'(4);
  localparam logic [XLEN-1:0] LSB_CLEAR  = ~XLEN'(1);

  logic [XLEN-1:0] immUpper, immJump, immReg;
  logic [XLEN-1:0] linkAddr, pcTarget, regSum, regTarget, nextPc, wbValue;
  logic [4:0]      destIdx;
  logic            writeEn;

  assign immUpper = XLEN'($signed({instr[31:12], 12'b0}));
  assign immJump  = XLEN'($signed({instr[31], instr[19:12], instr[20], instr[30:21], 1'b0}));
  assign immReg   = XLEN'($signed(instr[31:20]));
  assign destIdx  = instr[11:7];

  assign linkAddr  = pc + INSTR_STEP;
  assign pcTarget  = pc + immJump;
  assign regSum    = rs1Val + immReg;
  assign regTarget = regSum & LSB_CLEAR;

  always_comb begin
    if (ctrl.jumpReg)     nextPc = regTarget;
    else if (ctrl.jumpPc) nextPc = pcTarget;
    else                  nextPc = linkAddr;
  end

  // Two one-bit selects: the original select has priority over the added one.
  always_comb begin
    if (ctrl.selUpper)     wbValue = immUpper;
    else if (ctrl.selLink) wbValue = linkAddr;
    else                   wbValue = aluResult;
  end

  assign writeEn = ctrl.regWrite && (destIdx != 5'd0);

  // PC and write port share one edge; the link value is captured pre-update.
  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= RESET_PC;
      regWe  <= 1'b0;
      rdIdx  <= '0;
      rdData <= '0;
    end else begin
      pc     <= nextPc;
      regWe  <= writeEn;
      rdIdx  <= destIdx;
      rdData <= wbValue;
    end
  end

  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (pc == RESET_PC && !regWe && rdIdx == 5'd0));

  a_r2_sequential: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ctrl.jumpPc) && !$past(ctrl.jumpReg))
      |-> pc == $past(pc) + INSTR_STEP);

  a_r6_target_even: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ctrl.jumpReg)) |-> pc[0] == 1'b0);

  a_r7_link_old_pc: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && regWe && $past(ctrl.selLink) && !$past(ctrl.selUpper))
      |-> rdData == $past(pc) + INSTR_STEP);

  a_r8_no_x0_write: assert property (@(posedge clk) disable iff (rst)
    regWe |-> rdIdx != 5'd0);

  a_r9_no_ctrl_no_write: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ctrl.regWrite)) |-> !regWe);
endmodule

// File: rtl/jl_unit.sv
module jl_unit
  import jl_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] rs1Val,
  input  logic [XLEN-1:0] aluResult,
  output logic [XLEN-1:0] pc,
  output logic            regWe,
  output logic [4:0]      rdIdx,
  output logic [XLEN-1:0] rdData
);
  jlCtrl_t ctrl;

  jl_control u_control (
    .opcode (instr[6:0]),
    .funct3 (instr[14:12]),
    .ctrl   (ctrl)
  );

  jl_datapath #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_datapath (
    .clk       (clk),
    .rst       (rst),
    .instr     (instr),
    .rs1Val    (rs1Val),
    .aluResult (aluResult),
    .ctrl      (ctrl),
    .pc        (pc),
    .regWe     (regWe),
    .rdIdx     (rdIdx),
    .rdData    (rdData)
  );
endmodule

// File: tb/jl_unit_bench.sv
`timescale 1ns/1ps
module jl_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = '0, rs1Val = '0, aluResult = '0;
  logic [31:0] pc, rdData;
  logic        regWe;
  logic [4:0]  rdIdx;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [31:0] expPc = '0;

  always #2.5 clk = ~clk;

  jl_unit u_jl_unit (
    .clk(clk), .rst(rst), .instr(instr), .rs1Val(rs1Val), .aluResult(aluResult),
    .pc(pc), .regWe(regWe), .rdIdx(rdIdx), .rdData(rdData)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] encR(input logic [4:0] rd);
    return {7'b0, 5'd3, 5'd2, 3'b000, rd, 7'b0110011};
  endfunction
  function automatic logic [31:0] encU(input logic [4:0] rd, input logic [19:0] imm);
    return {imm, rd, 7'b0110111};
  endfunction
  function automatic logic [31:0] encJ(input logic [4:0] rd, input logic [20:0] off);
    return {off[20], off[10:1], off[11], off[19:12], rd, 7'b1101111};
  endfunction
  function automatic logic [31:0] encI(input logic [4:0] rd, input logic [4:0] rs1,
                                       input logic [2:0] f3, input logic [11:0] imm);
    return {imm, rs1, f3, rd, 7'b1100111};
  endfunction

  task automatic step(input logic [31:0] word, input logic [31:0] r1, input logic [31:0] alu,
                      input bit expWe, input logic [4:0] expRd, input logic [31:0] expData,
                      input logic [31:0] expNext, input string req);
    instr = word; rs1Val = r1; aluResult = alu;
    @(posedge clk);
    @(negedge clk);
    chk(pc == expNext, req, "pc", pc, expNext);
    chk(regWe == expWe, req, "regWe", {31'b0, regWe}, {31'b0, expWe});
    if (expWe) begin
      chk(rdIdx == expRd, req, "rdIdx", {27'b0, rdIdx}, {27'b0, expRd});
      chk(rdData == expData, req, "rdData", rdData, expData);
    end
    expPc = expNext;
  endtask

  task automatic doR(input logic [4:0] rd, input logic [31:0] alu);   // R3, R2, R8
    step(encR(rd), $urandom, alu, rd != 0, rd, alu, expPc + 4, (rd == 0) ? "R8" : "R3");
  endtask
  task automatic doU(input logic [4:0] rd, input logic [19:0] imm);   // R4
    step(encU(rd, imm), $urandom, $urandom, rd != 0, rd, {imm, 12'b0}, expPc + 4,
         (rd == 0) ? "R8" : "R4");
  endtask
  task automatic doJ(input logic [4:0] rd, input logic [20:0] off);   // R5, R7
    step(encJ(rd, off), $urandom, $urandom, rd != 0, rd, expPc + 4,
         expPc + {{11{off[20]}}, off}, (rd == 0) ? "R8" : "R5_R7");
  endtask
  task automatic doI(input logic [4:0] rd, input logic [31:0] r1, input logic [11:0] imm); // R6, R7
    logic [31:0] t;
    t = (r1 + {{20{imm[11]}}, imm}) & 32'hFFFF_FFFE;
    step(encI(rd, rd, 3'b000, imm), r1, $urandom, rd != 0, rd, expPc + 4, t,
         (rd == 0) ? "R8" : "R6_R7");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R10 watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    instr = encJ(5'd1, 21'h100);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(pc == 32'd0, "R1", "pc", pc, 32'd0);
    chk(!regWe, "R1", "regWe", {31'b0, regWe}, 32'd0);
    chk(rdIdx == 5'd0 && rdData == 32'd0, "R1", "rdData", rdData, 32'd0);
    rst = 1'b0;
    expPc = 32'd0;

    doR(5'd5, 32'hDEAD_BEEF);                 // R3, R2
    doU(5'd7, 20'hABCDE);                     // R4
    doR(5'd0, 32'h1234_5678);                 // R8
    doJ(5'd1, 21'h000100);                    // R5 forward
    doJ(5'd2, 21'h1FFFF8);                    // R5 backward
    doI(5'd6, 32'h0000_4001, 12'h002);        // R6 odd target, rd == rs1
    doI(5'd9, 32'h0000_8000, 12'hFFC);        // R6 negative imm
    doI(5'd0, 32'h0000_1000, 12'h010);        // R8 jump to x0
    // R9: bad funct3 and unknown opcode
    step(encI(5'd4, 5'd4, 3'b010, 12'h040), 32'h100, 32'h5, 1'b0, 5'd0, 32'd0, expPc + 4, "R9");
    step(32'h0000_0213, 32'h100, 32'h5, 1'b0, 5'd0, 32'd0, expPc + 4, "R9");
    // R10: write port follows the next instruction, not the held one
    doU(5'd31, 20'h00001);
    doR(5'd30, 32'h0000_0001);

    for (int i = 0; i < 400; i++) begin
      logic [4:0] rd;
      rd = 5'($urandom);
      case ($urandom % 5)
        0: doR(rd, $urandom);
        1: doU(rd, 20'($urandom));
        2: doJ(rd, {20'($urandom), 1'b0});
        3: doI(rd, $urandom, 12'($urandom));
        default: step(32'h0000_0003 | ($urandom & 32'hFFFF_FF80), $urandom, $urandom,
                      1'b0, 5'd0, 32'd0, expPc + 4, "R9");
      endcase
    end

    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(pc == 32'd0 && !regWe, "R1", "pc_reset_again", pc, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule